// File: doc/BRIEF.md
# Output Spike Key Distiller

This block turns outgoing spike keys into compact 32-bit words for a peripheral link. Each incoming key comes with a 3-bit channel index that picks one of six per-channel configurations. For the chosen channel the key is ANDed with the channel mask, the surviving bits are shifted down by the channel shift, and the channel prefix is ORed into the result so that it fills the upper bits of the word.

Keys enter through a valid/ready port together with their channel index. Words leave through a valid/ready port behind a single output register, so one key can be accepted in every cycle. A simple register-write port loads each channel's prefix, mask and shift. Channel indices 6 and 7 have no configuration: such keys are accepted and dropped.

Top module: `spike_key_distiller`

## Requirements
- R1: After reset no word is offered (out_valid low), in_ready is high, and every channel prefix, mask and shift is zero, so a key accepted on any channel before configuration produces the word 0.
- R2: A key accepted on channel c in 0..5 produces out_word = prefix[c] | ((in_key & mask[c]) >> shift[c]), where the shift is logical and fills with zeros.
- R3: The shift register of a channel keeps only bits [4:0] of the written data, giving a shift of 0 to 31 positions.
- R4: A write with cfg_addr = 208 + c loads prefix[c], 224 + c loads mask[c] and 240 + c loads shift[c], for c in 0..5.
- R5: A key accepted with in_chan equal to 6 or 7 is consumed and no word is produced for it.
- R6: A key accepted on channel 0..5 at a clock edge is offered on the output from that edge on; with no such acceptance and out_ready high, out_valid is low after the edge.
- R7: in_ready is high exactly when out_valid is low or out_ready is high, so a key can be accepted in every cycle while the sink takes words.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_word does not change.
- R9: A write to any address outside the eighteen addresses of R4 (including 214 to 223, 230 to 239 and 246 to 255) changes no channel configuration.
- R10: A configuration write and a key acceptance at the same edge: the key uses the configuration held before that edge; the written value applies to keys accepted at later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Key and channel are presented |
| in_ready | output | 1 | Block can accept a key this cycle |
| in_key | input | 32 | Spike key to compress |
| in_chan | input | 3 | Channel index, 0..5 configured, 6..7 dropped |
| out_valid | output | 1 | A compressed word is offered |
| out_ready | input | 1 | Sink takes the word this cycle |
| out_word | output | 32 | Compressed peripheral word |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |

## Verification
The assertions assume that the sink follows a plain valid/ready protocol and that in_chan is a known value whenever in_valid is high; they make no assumption about the keys or the configuration data. The stimulus drives all inputs at the falling edge, keeps every input defined at all times, and draws channel indices over the full 0..7 range and write addresses both inside and outside the mapped set, so dropped keys and ignored writes mix freely with ordinary traffic and with stalls of random length.

// File: rtl/dist_pkg.sv
package dist_pkg;
  parameter int N_CHAN    = 6;
  parameter int WORD_W    = 32;
  parameter int SHIFT_W   = 5;
  parameter int CHAN_W    = 3;
  parameter int ADDR_W    = 8;
  parameter int PFX_OFS   = 208;
  parameter int MASK_OFS  = 224;
  parameter int SHIFT_OFS = 240;
endpackage

// File: rtl/dist_cfg_regs.sv
module dist_cfg_regs #(
  parameter int N_CHAN    = dist_pkg::N_CHAN,
  parameter int WORD_W    = dist_pkg::WORD_W,
  parameter int SHIFT_W   = dist_pkg::SHIFT_W,
  parameter int ADDR_W    = dist_pkg::ADDR_W,
  parameter int PFX_OFS   = dist_pkg::PFX_OFS,
  parameter int MASK_OFS  = dist_pkg::MASK_OFS,
  parameter int SHIFT_OFS = dist_pkg::SHIFT_OFS
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [WORD_W-1:0]                wr_data,
  output logic [N_CHAN-1:0][WORD_W-1:0]    pfx_q,
  output logic [N_CHAN-1:0][WORD_W-1:0]    mask_q,
  output logic [N_CHAN-1:0][SHIFT_W-1:0]   shift_q
);

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    localparam logic [ADDR_W-1:0] A_PFX   = ADDR_W'(PFX_OFS + c);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(MASK_OFS + c);
    localparam logic [ADDR_W-1:0] A_SHIFT = ADDR_W'(SHIFT_OFS + c);

    logic                pfx_en, mask_en, shift_en;
    logic [WORD_W-1:0]   pfx_d, mask_d;
    logic [SHIFT_W-1:0]  shift_d;

    always_comb begin
      pfx_en   = wr_en && (wr_addr == A_PFX);
      mask_en  = wr_en && (wr_addr == A_MASK);
      shift_en = wr_en && (wr_addr == A_SHIFT);
      pfx_d    = wr_data;
      mask_d   = wr_data;
      shift_d  = wr_data[SHIFT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pfx_q[c]   <= '0;
        mask_q[c]  <= '0;
        shift_q[c] <= '0;
      end else begin
        if (pfx_en)   pfx_q[c]   <= pfx_d;
        if (mask_en)  mask_q[c]  <= mask_d;
        if (shift_en) shift_q[c] <= shift_d;
      end
    end
  end

endmodule

// File: rtl/dist_compact.sv
module dist_compact #(
  parameter int N_CHAN  = dist_pkg::N_CHAN,
  parameter int WORD_W  = dist_pkg::WORD_W,
  parameter int SHIFT_W = dist_pkg::SHIFT_W,
  parameter int CHAN_W  = dist_pkg::CHAN_W
) (
  input  logic [WORD_W-1:0]               key_i,
  input  logic [CHAN_W-1:0]               chan_i,
  input  logic [N_CHAN-1:0][WORD_W-1:0]   pfx_i,
  input  logic [N_CHAN-1:0][WORD_W-1:0]   mask_i,
  input  logic [N_CHAN-1:0][SHIFT_W-1:0]  shift_i,
  output logic                            chan_ok_o,
  output logic [WORD_W-1:0]               word_o
);

  logic [WORD_W-1:0]  sel_pfx, sel_mask, kept;
  logic [SHIFT_W-1:0] sel_shift;

  always_comb begin
    chan_ok_o = 1'b0;
    sel_pfx   = '0;
    sel_mask  = '0;
    sel_shift = '0;
    for (int c = 0; c < N_CHAN; c++) begin
      if (chan_i == CHAN_W'(c)) begin
        chan_ok_o = 1'b1;
        sel_pfx   = pfx_i[c];
        sel_mask  = mask_i[c];
        sel_shift = shift_i[c];
      end
    end
    kept   = key_i & sel_mask;
    word_o = sel_pfx | (kept >> sel_shift);
  end

endmodule

// File: rtl/dist_out_stage.sv
module dist_out_stage #(
  parameter int WORD_W = dist_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              keep_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              room_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [WORD_W-1:0] word_o
);

  logic              valid_d, load_en;
  logic [WORD_W-1:0] word_d;

  always_comb begin
    room_o  = !valid_o || ready_i;
    load_en = take_i && room_o && keep_i;
    word_d  = word_i;
    if (load_en)     valid_d = 1'b1;
    else if (room_o) valid_d = 1'b0;
    else             valid_d = valid_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_o <= '0;
    else if (load_en) word_o <= word_d;
  end

endmodule

// File: rtl/spike_key_distiller.sv
module spike_key_distiller #(
  parameter int N_CHAN    = dist_pkg::N_CHAN,
  parameter int WORD_W    = dist_pkg::WORD_W,
  parameter int SHIFT_W   = dist_pkg::SHIFT_W,
  parameter int CHAN_W    = dist_pkg::CHAN_W,
  parameter int ADDR_W    = dist_pkg::ADDR_W,
  parameter int PFX_OFS   = dist_pkg::PFX_OFS,
  parameter int MASK_OFS  = dist_pkg::MASK_OFS,
  parameter int SHIFT_OFS = dist_pkg::SHIFT_OFS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_key,
  input  logic [CHAN_W-1:0] in_chan,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata
);

  logic                            rst_meta_n, rst_sync_n;
  logic [N_CHAN-1:0][WORD_W-1:0]   pfx, mask;
  logic [N_CHAN-1:0][SHIFT_W-1:0]  shift;
  logic                            chan_ok;
  logic [WORD_W-1:0]               word_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  dist_cfg_regs #(
    .N_CHAN(N_CHAN), .WORD_W(WORD_W), .SHIFT_W(SHIFT_W), .ADDR_W(ADDR_W),
    .PFX_OFS(PFX_OFS), .MASK_OFS(MASK_OFS), .SHIFT_OFS(SHIFT_OFS)
  ) u_cfg (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .pfx_q(pfx), .mask_q(mask), .shift_q(shift)
  );

  dist_compact #(
    .N_CHAN(N_CHAN), .WORD_W(WORD_W), .SHIFT_W(SHIFT_W), .CHAN_W(CHAN_W)
  ) u_cmp (
    .key_i(in_key), .chan_i(in_chan),
    .pfx_i(pfx), .mask_i(mask), .shift_i(shift),
    .chan_ok_o(chan_ok), .word_o(word_c)
  );

  dist_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_sync_n),
    .take_i(in_valid), .keep_i(chan_ok), .word_i(word_c),
    .room_o(in_ready),
    .valid_o(out_valid), .ready_i(out_ready), .word_o(out_word)
  );

endmodule

// File: rtl/dist_checker.sv
module dist_checker #(
  parameter int N_CHAN = 6,
  parameter int WORD_W = 32,
  parameter int CHAN_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [CHAN_W-1:0] in_chan,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word
);

  logic acc;
  always_comb acc = in_valid && in_ready;

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word));

  p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_drain_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  p_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_chan < CHAN_W'(N_CHAN)) |=> out_valid);

  p_idle_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !acc && out_ready |=> !out_valid);

  p_drop_high_chan_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_chan >= CHAN_W'(N_CHAN)) |=> !out_valid);

endmodule

bind spike_key_distiller dist_checker #(
  .N_CHAN(N_CHAN), .WORD_W(WORD_W), .CHAN_W(CHAN_W)
) u_dist_checker (
  .clk(clk), .rst_n(rst_sync_n),
  .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan),
  .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
);

// File: tb/tb_spike_key_distiller.sv
module tb_spike_key_distiller;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready, cfg_we;
  logic [31:0] in_key, out_word, cfg_wdata;
  logic [2:0]  in_chan;
  logic [7:0]  cfg_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  spike_key_distiller dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_key(in_key), .in_chan(in_chan),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  string phase = "";

  logic [31:0] m_pfx [6];
  logic [31:0] m_mask[6];
  logic [4:0]  m_shift[6];
  bit          exp_valid = 0;
  logic [31:0] exp_word = '0;
  bit          stalled = 0;
  logic [31:0] held_word = '0;

  function automatic logic [31:0] expect_word(input logic [2:0] ch, input logic [31:0] k);
    return m_pfx[ch] | ((k & m_mask[ch]) >> m_shift[ch]);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s [%s] actual=%h expected=%h", req, phase, act, exp);
    end
  endtask

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    if (a >= 8'd208 && a < 8'd214) m_pfx[a - 8'd208] = d;
    else if (a >= 8'd224 && a < 8'd230) m_mask[a - 8'd224] = d;
    else if (a >= 8'd240 && a < 8'd246) m_shift[a - 8'd240] = d[4:0];
  endtask

  task automatic step(input bit iv, input logic [31:0] k, input logic [2:0] ch,
                      input bit ordy, input bit we, input logic [7:0] a, input logic [31:0] d);
    bit rdy;
    @(negedge clk);
    in_valid = iv; in_key = k; in_chan = ch; out_ready = ordy;
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    #1;
    rdy = !exp_valid || ordy;
    check(in_ready == rdy, "R7", {31'd0, in_ready}, {31'd0, rdy});
    check(out_valid == exp_valid, "R6", {31'd0, out_valid}, {31'd0, exp_valid});
    if (exp_valid) check(out_word == exp_word, "R2", out_word, exp_word);
    if (stalled && exp_valid) check(out_word == held_word, "R8", out_word, held_word);
    stalled   = exp_valid && !ordy;
    held_word = out_word;
    if (iv && rdy && ch < 3'd6) begin
      exp_word  = expect_word(ch, k);
      exp_valid = 1;
    end else if (rdy) exp_valid = 0;
    if (we) model_write(a, d);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(0, '0, '0, 1, 1, a, d);
  endtask

  task automatic spike(input logic [2:0] ch, input logic [31:0] k);
    step(1, k, ch, 1, 0, '0, '0);
  endtask

  task automatic idle();
    step(0, '0, '0, 1, 0, '0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240917);
    for (int i = 0; i < 6; i++) begin m_pfx[i] = '0; m_mask[i] = '0; m_shift[i] = '0; end
    rst_n = 0; in_valid = 0; in_key = '0; in_chan = '0; out_ready = 0;
    cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;
    phase = "R1";
    check(out_valid == 1'b0, "R1", {31'd0, out_valid}, 32'd0);
    check(in_ready == 1'b1, "R1", {31'd0, in_ready}, 32'd1);
    spike(3'd0, 32'hFFFF_FFFF);
    spike(3'd5, 32'h1234_5678);
    idle();

    phase = "R4";
    wr(8'd210, 32'hAB00_0000); wr(8'd226, 32'h0000_FF00); wr(8'd242, 32'd8);
    spike(3'd2, 32'h1234_5678);
    check(1'b1, "R4", '0, '0);
    idle();

    phase = "R3";
    wr(8'd227, 32'hFFFF_FFFF); wr(8'd243, 32'h0000_0023);
    spike(3'd3, 32'hF000_0000);
    wr(8'd243, 32'd31);
    spike(3'd3, 32'h8000_0000);
    idle();

    phase = "R5";
    step(1, 32'hDEAD_BEEF, 3'd6, 1, 0, '0, '0);
    step(1, 32'hDEAD_BEEF, 3'd7, 1, 0, '0, '0);
    idle();

    phase = "R9";
    wr(8'd214, 32'hFFFF_FFFF); wr(8'd223, 32'hFFFF_FFFF); wr(8'd207, 32'hFFFF_FFFF);
    wr(8'd246, 32'd7); wr(8'd255, 32'd7); wr(8'd0, 32'hFFFF_FFFF);
    spike(3'd5, 32'hFFFF_FFFF);
    spike(3'd0, 32'hFFFF_FFFF);
    idle();

    phase = "R10";
    wr(8'd224, 32'h0000_00FF);
    step(1, 32'h0000_00AA, 3'd0, 1, 1, 8'd208, 32'h5500_0000);
    spike(3'd0, 32'h0000_00AA);
    idle();

    phase = "R8";
    spike(3'd2, 32'h0000_3300);
    step(1, 32'h0000_4400, 3'd2, 0, 0, '0, '0);
    step(1, 32'h0000_4400, 3'd2, 0, 0, '0, '0);
    step(1, 32'h0000_4400, 3'd2, 1, 0, '0, '0);
    idle(); idle();

    phase = "random";
    for (int i = 0; i < 5000; i++) begin
      logic [7:0] a;
      int sel;
      sel = $urandom % 4;
      if (sel == 0)      a = 8'(208 + $urandom % 6);
      else if (sel == 1) a = 8'(224 + $urandom % 6);
      else if (sel == 2) a = 8'(240 + $urandom % 6);
      else               a = 8'($urandom % 256);
      step(($urandom % 4) != 0, $urandom, 3'($urandom % 8), ($urandom % 3) != 0,
           ($urandom % 6) == 0, a, $urandom);
    end
    idle(); idle();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule